// File: doc/BRIEF.md
# Command-Indexed Bank Select Controller

This block sits on a cartridge and turns CPU writes into bank settings, then uses those settings to turn CPU program addresses and pattern-memory addresses into physical ROM addresses. Software programs it in two steps. It first writes a command index that names one of eight bank slots. It then writes a page number, which goes into the slot that the command named. Six slots hold 1 KB pattern pages. Two of those six cover 2 KB pairs, so their lowest page bit is replaced by the address. The other two slots hold 8 KB program pages.

The program space 0x8000–0xFFFF is split into four 8 KB windows. The two upper windows always show the last two pages of the program ROM. A swap flag exchanges the two lower switchable windows. Any later command write clears that flag. A separate flag selects the nametable mirroring. Translation is purely combinational from the current register state. Register writes take effect at the rising clock edge on which they are presented.

Top module: `cmd_bank_mapper`

## Requirements
- R1: After reset the command index is 0, all six pattern bank registers are 0, the program slots hold pages 0 (command 6) and 1 (command 7), mirroring is 0 (vertical) and swap is off.
- R2: A write with cpu_addr[15:13]=3'b100 and cpu_addr[0]=0 loads the command index from cpu_wdata[2:0]; cpu_wdata[7:3] is ignored. Bits 12:1 of the address do not matter for any port.
- R3: A write with cpu_addr[0]=1 and cpu_addr[15:13] equal to 3'b100 or 3'b101 stores cpu_wdata, truncated to the slot's page width, into the slot named by the current command.
- R4: Pattern addresses 0x0000–0x07FF use slot 0 and 0x0800–0x0FFF use slot 1. For both, chr_addr = {slot value with bit 0 replaced by ppu_addr[10], ppu_addr[9:0]}.
- R5: Pattern addresses 0x1000, 0x1400, 0x1800 and 0x1C00 (1 KB each) use slots 2, 3, 4 and 5: chr_addr = {slot value, ppu_addr[9:0]}.
- R6: With swap off, prg_addr = {page, cpu_addr[12:0]}. The page comes from slot 6 when cpu_addr[14:13]=0 and from slot 7 when cpu_addr[14:13]=1.
- R7: cpu_addr[14:13]=2 maps to the second-to-last program page and 3 maps to the last program page, whatever the register state.
- R8: A write with cpu_addr[15:13]=3'b101 and cpu_addr[0]=0 sets mirror_horiz to cpu_wdata[0] (1 = horizontal).
- R9: A write with cpu_addr[15:13]=3'b111 and cpu_addr[0]=0 sets swap to cpu_wdata[5]. With swap on, window 0 shows slot 7 and window 1 shows slot 6.
- R10: A command write (R2) also turns swap off.
- R11: Writes to cpu_addr[15:13]=3'b110 (either parity), odd addresses in 0xE000–0xFFFF, or any address below 0x8000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for both write decode and translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Pattern-memory address 0x0000–0x1FFF |
| prg_addr | output | PRG_PAGE_W+13 | Program ROM address |
| chr_addr | output | CHR_PAGE_W+10 | Pattern ROM address |
| mirror_horiz | output | 1 | Mirroring select, 1 = horizontal |

## Verification
A write shown on the ports is captured at the next rising edge. From then on both translated addresses and mirror_horiz reflect it with no further delay, because translation is combinational. The bench drives a write on a falling edge and removes it on the next falling edge, at which point it updates its model. It then moves the address inputs on a falling edge and samples one nanosecond later. Each result is therefore read one edge after the write that caused it, and well away from the next active edge.

// File: rtl/cmd_bank_mapper.sv
module cmd_bank_mapper #(
  parameter int PRG_PAGE_W = 6,
  parameter int CHR_PAGE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_wr,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic [12:0]             ppu_addr,
  output logic [PRG_PAGE_W+12:0]  prg_addr,
  output logic [CHR_PAGE_W+9:0]   chr_addr,
  output logic                    mirror_horiz
);

  localparam logic [PRG_PAGE_W-1:0] PG_LAST = '1;
  localparam logic [PRG_PAGE_W-1:0] PG_PREV = {{(PRG_PAGE_W-1){1'b1}}, 1'b0};

  logic [2:0]            cmd;
  logic                  swap;
  logic [CHR_PAGE_W-1:0] chr_bank [6];
  logic [PRG_PAGE_W-1:0] prg_bank [2];

  wire       hit      = cpu_wr && cpu_addr[15];
  wire [2:0] port     = {cpu_addr[14:13], cpu_addr[0]};
  wire       wr_cmd   = hit && port == 3'b000;
  wire       wr_val   = hit && (port == 3'b001 || port == 3'b011);
  wire       wr_mir   = hit && port == 3'b010;
  wire       wr_swap  = hit && port == 3'b110;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd          <= '0;
      swap         <= 1'b0;
      mirror_horiz <= 1'b0;
      for (int i = 0; i < 6; i++) chr_bank[i] <= '0;
      prg_bank[0]  <= '0;
      prg_bank[1]  <= PRG_PAGE_W'(1);
    end else begin
      if (wr_cmd) begin
        cmd  <= cpu_wdata[2:0];
        swap <= 1'b0;
      end
      if (wr_swap) swap <= cpu_wdata[5];
      if (wr_mir) mirror_horiz <= cpu_wdata[0];
      if (wr_val) begin
        for (int i = 0; i < 6; i++)
          if (cmd == 3'(i)) chr_bank[i] <= cpu_wdata[CHR_PAGE_W-1:0];
        if (cmd[2:1] == 2'b11) prg_bank[cmd[0]] <= cpu_wdata[PRG_PAGE_W-1:0];
      end
    end
  end

  logic [PRG_PAGE_W-1:0] prg_page;
  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    prg_page = swap ? prg_bank[1] : prg_bank[0];
      2'd1:    prg_page = swap ? prg_bank[0] : prg_bank[1];
      2'd2:    prg_page = PG_PREV;
      default: prg_page = PG_LAST;
    endcase
  end
  assign prg_addr = {prg_page, cpu_addr[12:0]};

  logic [CHR_PAGE_W-1:0] chr_page;
  always_comb begin
    unique case (ppu_addr[12:10])
      3'd0, 3'd1: chr_page = {chr_bank[0][CHR_PAGE_W-1:1], ppu_addr[10]};
      3'd2, 3'd3: chr_page = {chr_bank[1][CHR_PAGE_W-1:1], ppu_addr[10]};
      3'd4:       chr_page = chr_bank[2];
      3'd5:       chr_page = chr_bank[3];
      3'd6:       chr_page = chr_bank[4];
      default:    chr_page = chr_bank[5];
    endcase
  end
  assign chr_addr = {chr_page, ppu_addr[9:0]};

  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14] |-> prg_addr[PRG_PAGE_W+12:14] == PG_LAST[PRG_PAGE_W-1:1] && prg_addr[13] == cpu_addr[13]); // R7

  AST_PAIR_LOW_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[12] |-> chr_addr[10] == ppu_addr[10]); // R4

  AST_CMD_CLEARS_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b100 && !cpu_addr[0]) |=> !swap); // R10

  AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b101 && !cpu_addr[0]) |=> mirror_horiz == $past(cpu_wdata[0])); // R8

  AST_SWAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b111 && !cpu_addr[0]) |=> swap == $past(cpu_wdata[5])); // R9

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && (!cpu_addr[15] || cpu_addr[15:13] == 3'b110 || (cpu_addr[15:13] == 3'b111 && cpu_addr[0])))
    |=> $stable(mirror_horiz) && $stable(swap) && $stable(cmd)); // R11

endmodule

// File: tb/tb_cmd_bank_mapper.sv
`timescale 1ns/1ps
module tb_cmd_bank_mapper;
  localparam int PW = 6;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [12:0] ppu_addr = '0;
  logic [PW+12:0] prg_addr;
  logic [CW+9:0]  chr_addr;
  logic mirror_horiz;

  cmd_bank_mapper #(.PRG_PAGE_W(PW), .CHR_PAGE_W(CW)) dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  int m_cmd, m_mir, m_swap;
  int m_bank [8];

  function automatic logic [PW+12:0] exp_prg(logic [15:0] a);
    int pg;
    case (a[14:13])
      2'd0: pg = m_swap ? m_bank[7] : m_bank[6];
      2'd1: pg = m_swap ? m_bank[6] : m_bank[7];
      2'd2: pg = (1 << PW) - 2;
      default: pg = (1 << PW) - 1;
    endcase
    return {pg[PW-1:0], a[12:0]};
  endfunction

  function automatic logic [CW+9:0] exp_chr(logic [12:0] p);
    int s, pg;
    s = int'(p[12:10]);
    if (s < 2)      pg = (m_bank[0] & ~1) | int'(p[10]);
    else if (s < 4) pg = (m_bank[1] & ~1) | int'(p[10]);
    else            pg = m_bank[s - 2];
    return {pg[CW-1:0], p[9:0]};
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_mir = 0; m_swap = 0;
    foreach (m_bank[i]) m_bank[i] = 0;
    m_bank[7] = 1;
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (!a[15]) return;
    case ({a[14:13], a[0]})
      3'b000: begin m_cmd = int'(d[2:0]); m_swap = 0; end
      3'b001, 3'b011: m_bank[m_cmd] = (m_cmd >= 6) ? int'(d[PW-1:0]) : int'(d[CW-1:0]);
      3'b010: m_mir = int'(d[0]);
      3'b110: m_swap = int'(d[5]);
      default: ;
    endcase
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 0;
    model_write(a, d);
  endtask

  task automatic chk_prg(logic [15:0] a, string tag);
    logic [PW+12:0] e;
    @(negedge clk); cpu_addr = a; #1;
    e = exp_prg(a);
    total++;
    if (prg_addr !== e) begin
      bad++;
      $display("FAIL %s prg addr %h: actual %h expected %h", tag, a, prg_addr, e);
    end
  endtask

  task automatic chk_chr(logic [12:0] p, string tag);
    logic [CW+9:0] e;
    @(negedge clk); ppu_addr = p; #1;
    e = exp_chr(p);
    total++;
    if (chr_addr !== e) begin
      bad++;
      $display("FAIL %s chr addr %h: actual %h expected %h", tag, p, chr_addr, e);
    end
  endtask

  task automatic chk_mir(string tag);
    @(negedge clk); #1;
    total++;
    if (mirror_horiz !== 1'(m_mir)) begin
      bad++;
      $display("FAIL %s mirror: actual %0d expected %0d", tag, mirror_horiz, m_mir);
    end
  endtask

  task automatic chk_all(string tag);
    for (int w = 0; w < 4; w++) chk_prg(16'(16'h8000 + w * 16'h2000 + 16'h0123), tag);
    for (int s = 0; s < 8; s++) chk_chr(13'(s * 13'h400 + 13'h2A5), tag);
    chk_mir(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [9];
    void'($urandom(32'h5EED1));
    bases = '{16'h8000, 16'h8001, 16'hA000, 16'hA001, 16'hC000, 16'hC001, 16'hE000, 16'hE001, 16'h6000};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    chk_all("R1");

    wr(16'h8000, 8'hFE);               // R2: upper data bits ignored -> command 6
    wr(16'h8001, 8'h05);               // R3
    chk_prg(16'h8010, "R6");
    wr(16'h9FFE, 8'h07);               // R2 mirrored port
    wr(16'hA001, 8'h2A);               // R3 alternate value port
    chk_prg(16'hA777, "R6");
    chk_prg(16'hC000, "R7");
    chk_prg(16'hFFFF, "R7");

    wr(16'h8000, 8'h00); wr(16'h8001, 8'h05);
    chk_chr(13'h0000, "R4"); chk_chr(13'h0400, "R4");
    wr(16'h8000, 8'h01); wr(16'h8001, 8'hC4);
    chk_chr(13'h0800, "R4"); chk_chr(13'h0FFF, "R4");
    for (int c = 2; c < 6; c++) begin
      wr(16'h8000, 8'(c)); wr(16'h8001, 8'(8'h31 + c * 8'h11));
    end
    for (int s = 4; s < 8; s++) chk_chr(13'(s * 13'h400 + 13'h3FF), "R5");

    wr(16'hA000, 8'h01); chk_mir("R8");
    wr(16'hA002, 8'h00); chk_mir("R8");

    wr(16'hE000, 8'h20);
    chk_prg(16'h8000, "R9"); chk_prg(16'hA000, "R9"); chk_prg(16'hC000, "R9");
    wr(16'h8000, 8'h06);
    chk_prg(16'h8000, "R10"); chk_prg(16'hA000, "R10");
    wr(16'hE000, 8'h20); wr(16'hE000, 8'hDF);
    chk_prg(16'h8000, "R9");

    wr(16'hE000, 8'h20);
    wr(16'hA000, 8'h01);
    wr(16'hC000, 8'hFF); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    wr(16'h6000, 8'h00); wr(16'h0001, 8'h55); wr(16'hDFFF, 8'h00);
    chk_all("R11");
    wr(16'h8001, 8'h11);               // value goes to command 6 still
    chk_prg(16'hA000, "R3");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int k;
      k = int'($urandom % 9);
      a = bases[k];
      if (k < 8) a = a | (16'($urandom) & 16'h1FFE);
      d = 8'($urandom);
      wr(a, d);
      chk_prg(16'h8000 | 16'($urandom), "R6");
      chk_chr(13'($urandom), "R5");
      if (i % 16 == 0) chk_all("R11");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule